// File: doc/BRIEF.md
# Load/Store Address Conflict Queues

This block sits between an out-of-order core's memory instruction issue and a single memory port. It keeps two small first-in first-out queues: one holds pending loads and one holds pending stores with their write data. Before an operation is accepted it is compared on its full word address against the other queue. A load that would read a location an older pending store has not yet written is held back. A store that would overwrite a location an older pending load has not yet read is held back too. Stores leave strictly in acceptance order, so two writes to one address can never swap.

Requests use a valid/ready handshake. Each queue reports its ready low either when it is full or when the request conflicts. It stays low until the older matching entry has left through the memory port. The memory port offers one operation per cycle, chosen from the two queue heads. When both queues hold work, the two queues take turns. A flush input empties both queues at once, for example after a mispredicted branch.

Top module: `mem_order_queues`

## Requirements
- R1: After reset both ready outputs are high and mem_valid is low.
- R2: Loads reach the memory port in the order they were accepted. While a load is offered, mem_is_store is 0 and mem_data is all zeros.
- R3: Stores reach the memory port in the order they were accepted, with the address and data that came with them. mem_is_store is 1 while a store is offered.
- R4: ld_ready is low while any store still held in the store queue has an address equal to ld_addr.
- R5: st_ready is low while any load still held in the load queue has an address equal to st_addr.
- R6: If a load and a store with equal addresses are presented in the same cycle and the load is accepted, the store is held (st_ready low) in that cycle. The load counts as the older of the two.
- R7: A queue holding DEPTH entries drives its ready low and accepts nothing.
- R8: If only one queue holds entries, its head is offered. If both hold entries, the queue not granted by the last transfer is offered. The first such tie after reset or flush goes to the load queue.
- R9: While mem_valid is high and mem_ready is low, the offer (mem_is_store, mem_addr, mem_data) stays unchanged in the next cycle, unless a flush occurs.
- R10: A flush empties both queues in one cycle, drops any push from the same cycle, and restarts the turn-taking of R8. mem_valid is low in the cycle after a flush.
- R11: Conflict checks compare every address bit. Addresses that differ in any single bit, including the most significant one, never conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty both queues |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | ADDR_W | Load word address |
| ld_ready | output | 1 | Load request accepted this cycle if ld_valid |
| st_valid | input | 1 | Store request present |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store write data |
| st_ready | output | 1 | Store request accepted this cycle if st_valid |
| mem_valid | output | 1 | An operation is offered to memory |
| mem_ready | input | 1 | Memory takes the offered operation |
| mem_is_store | output | 1 | 1 = offered operation is a store, 0 = load |
| mem_addr | output | ADDR_W | Offered word address |
| mem_data | output | DATA_W | Write data for a store; zero for a load |

## Verification
The bench builds the block with DEPTH=4, ADDR_W=4 and DATA_W=8. With only sixteen word addresses, random traffic keeps colliding with queued entries, so the read-after-write, write-after-read and same-cycle holds happen thousands of times. Full queues are also common, since mem_ready is throttled at random. Some directed cases use address pairs that differ only in the top bit, which covers the full-width comparison. Flushes are mixed into traffic while entries are held and pushes are pending.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;
  // Which queue head owns the memory port in a cycle.
  typedef enum logic {
    GRANT_LOAD  = 1'b0,
    GRANT_STORE = 1'b1
  } grant_e;
endpackage

// File: rtl/mo_addr_match.sv
// Compares one key against every entry of a queue; hit if any valid entry matches.
module mo_addr_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]             key,
  input  logic [DEPTH-1:0]              ent_valid,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
  output logic                          hit
);
  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = ent_valid[g] && (ent_addr[g] == key);
  end

  assign hit = |eq;
endmodule

// File: rtl/mo_addr_fifo.sv
// Small FIFO whose entry addresses are all visible for conflict checking.
module mo_addr_fifo #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          push,
  input  logic [ADDR_W-1:0]             push_addr,
  input  logic [DATA_W-1:0]             push_data,
  input  logic                          pop,
  output logic                          full,
  output logic                          empty,
  output logic [ADDR_W-1:0]             head_addr,
  output logic [DATA_W-1:0]             head_data,
  output logic [DEPTH-1:0]              ent_valid,
  output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][ADDR_W-1:0] addr_mem;
  logic [DEPTH-1:0][DATA_W-1:0] data_mem;
  logic [PW-1:0]                wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CW-1:0]                cnt, cnt_nxt;
  logic [DEPTH-1:0]             vld, vld_nxt;

  assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
  assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;

  always_comb begin
    vld_nxt = vld;
    cnt_nxt = cnt;
    if (pop) begin
      vld_nxt[rd_ptr] = 1'b0;
      cnt_nxt         = cnt_nxt - 1'b1;
    end
    if (push) begin
      vld_nxt[wr_ptr] = 1'b1;
      cnt_nxt         = cnt_nxt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      vld    <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      cnt <= cnt_nxt;
      vld <= vld_nxt;
    end
  end

  // Storage without reset; only entries marked valid are ever looked at.
  always_ff @(posedge clk) begin
    if (push && !flush) begin
      addr_mem[wr_ptr] <= push_addr;
      data_mem[wr_ptr] <= push_data;
    end
  end

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign head_addr = addr_mem[rd_ptr];
  assign head_data = data_mem[rd_ptr];
  assign ent_valid = vld;
  assign ent_addr  = addr_mem;

  assert_no_push_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_pop_when_empty_R2: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_count_tracks_valid_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(vld) == cnt);
endmodule

// File: rtl/mo_port_arbiter.sv
// Picks which queue head is offered to memory; alternates on ties and
// freezes the choice while an offer waits.
module mo_port_arbiter
  import mem_order_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   flush,
  input  logic   ld_avail,
  input  logic   st_avail,
  input  logic   mem_ready,
  output grant_e grant,
  output logic   mem_valid,
  output logic   fire
);
  logic   last_was_load;
  logic   hold_v;
  grant_e hold_g;

  assign mem_valid = ld_avail || st_avail;
  assign fire      = mem_valid && mem_ready;

  always_comb begin
    if (hold_v)         grant = hold_g;
    else if (!ld_avail) grant = GRANT_STORE;
    else if (!st_avail) grant = GRANT_LOAD;
    else                grant = last_was_load ? GRANT_STORE : GRANT_LOAD;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      last_was_load <= 1'b0;
      hold_v        <= 1'b0;
      hold_g        <= GRANT_LOAD;
    end else if (fire) begin
      last_was_load <= (grant == GRANT_LOAD);
      hold_v        <= 1'b0;
    end else if (mem_valid) begin
      hold_v <= 1'b1;
      hold_g <= grant;
    end
  end

  assert_turn_after_load_R8: assert property (@(posedge clk) disable iff (rst || flush)
    (fire && grant == GRANT_LOAD) |=> (!st_avail || grant == GRANT_STORE));
  assert_single_side_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_avail && !st_avail) |-> grant == GRANT_LOAD);
endmodule

// File: rtl/mem_order_queues.sv
module mem_order_queues
  import mem_order_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_ready,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_ready,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_is_store,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  logic                         ld_full, ld_empty, st_full, st_empty;
  logic [DEPTH-1:0]             ld_ent_v, st_ent_v;
  logic [DEPTH-1:0][ADDR_W-1:0] ld_ent_a, st_ent_a;
  logic [ADDR_W-1:0]            ld_head_a, st_head_a;
  logic [DATA_W-1:0]            ld_head_d, st_head_d;
  logic                         ld_conf, st_conf, st_same;
  logic                         ld_push, st_push, ld_pop, st_pop, fire;
  grant_e                       grant;

  // Load vs. older stores (read after write).
  mo_addr_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ld_chk (
    .key(ld_addr), .ent_valid(st_ent_v), .ent_addr(st_ent_a), .hit(ld_conf));

  // Store vs. older loads (write after read).
  mo_addr_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_st_chk (
    .key(st_addr), .ent_valid(ld_ent_v), .ent_addr(ld_ent_a), .hit(st_conf));

  assign ld_ready = !ld_full && !ld_conf;
  assign ld_push  = ld_valid && ld_ready;
  assign st_same  = ld_push && (ld_addr == st_addr);
  assign st_ready = !st_full && !st_conf && !st_same;
  assign st_push  = st_valid && st_ready;

  mo_addr_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ld_q (
    .clk(clk), .rst(rst), .flush(flush),
    .push(ld_push), .push_addr(ld_addr), .push_data('0), .pop(ld_pop),
    .full(ld_full), .empty(ld_empty), .head_addr(ld_head_a), .head_data(ld_head_d),
    .ent_valid(ld_ent_v), .ent_addr(ld_ent_a));

  mo_addr_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_st_q (
    .clk(clk), .rst(rst), .flush(flush),
    .push(st_push), .push_addr(st_addr), .push_data(st_data), .pop(st_pop),
    .full(st_full), .empty(st_empty), .head_addr(st_head_a), .head_data(st_head_d),
    .ent_valid(st_ent_v), .ent_addr(st_ent_a));

  mo_port_arbiter u_arb (
    .clk(clk), .rst(rst), .flush(flush),
    .ld_avail(!ld_empty), .st_avail(!st_empty), .mem_ready(mem_ready),
    .grant(grant), .mem_valid(mem_valid), .fire(fire));

  assign mem_is_store = (grant == GRANT_STORE);
  assign ld_pop       = fire && !mem_is_store && !flush;
  assign st_pop       = fire &&  mem_is_store && !flush;
  assign mem_addr     = mem_is_store ? st_head_a : ld_head_a;
  assign mem_data     = mem_is_store ? st_head_d : ld_head_d;

  assert_offer_holds_R9: assert property (@(posedge clk) disable iff (rst || flush)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_is_store) && $stable(mem_addr) && $stable(mem_data)));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> !mem_valid);
  assert_same_cycle_store_waits_R6: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && st_valid && ld_addr == st_addr) |-> !st_ready);
  assert_load_offer_zero_data_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_is_store) |-> (mem_data == '0));
endmodule

// File: tb/test_mem_order_queues.sv
module test_mem_order_queues;
  localparam int DEPTH = 4;
  localparam int AW    = 4;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic          ld_valid = 1'b0, st_valid = 1'b0, mem_ready = 1'b0;
  logic [AW-1:0] ld_addr = '0, st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          ld_ready, st_ready, mem_valid, mem_is_store;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mem_order_queues #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) i_mem_order_queues (
    .clk(clk), .rst(rst), .flush(flush),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_is_store(mem_is_store),
    .mem_addr(mem_addr), .mem_data(mem_data));

  // Behavioural reference state
  int mlq[$];
  int msq_a[$];
  int msq_d[$];
  int last_ld = 0, hold_v = 0, hold_s = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    mlq.delete(); msq_a.delete(); msq_d.delete();
    last_ld = 0; hold_v = 0; hold_s = 0;
  endtask

  // Inputs are set at a falling edge; compare, then advance one clock.
  task automatic step(string tag);
    bit ld_hit = 0, st_hit = 0, e_ldr, e_str, ld_acc, st_acc, e_mv, fire;
    int e_is = 0, e_addr = 0, e_data = 0;
    #1;
    foreach (msq_a[i]) if (msq_a[i] == int'(ld_addr)) ld_hit = 1;
    e_ldr  = (mlq.size() < DEPTH) && !ld_hit;
    ld_acc = ld_valid && e_ldr;
    foreach (mlq[i]) if (mlq[i] == int'(st_addr)) st_hit = 1;
    if (ld_acc && ld_addr == st_addr) st_hit = 1;
    e_str  = (msq_a.size() < DEPTH) && !st_hit;
    st_acc = st_valid && e_str;
    e_mv   = (mlq.size() > 0) || (msq_a.size() > 0);
    if (hold_v != 0)            e_is = hold_s;
    else if (mlq.size() == 0)   e_is = 1;
    else if (msq_a.size() == 0) e_is = 0;
    else                        e_is = last_ld;
    if (e_mv) begin
      e_addr = (e_is != 0) ? msq_a[0] : mlq[0];
      e_data = (e_is != 0) ? msq_d[0] : 0;
    end
    fire = e_mv && mem_ready;
    chk(tag, "ld_ready", int'(ld_ready), int'(e_ldr));
    chk(tag, "st_ready", int'(st_ready), int'(e_str));
    chk(tag, "mem_valid", int'(mem_valid), int'(e_mv));
    if (e_mv) begin
      chk(tag, "mem_is_store", int'(mem_is_store), e_is);
      chk(tag, "mem_addr", int'(mem_addr), e_addr);
      chk(tag, "mem_data", int'(mem_data), e_data);
    end
    @(posedge clk);
    if (flush) model_clear();
    else begin
      if (fire) begin
        if (e_is != 0) begin void'(msq_a.pop_front()); void'(msq_d.pop_front()); end
        else void'(mlq.pop_front());
        last_ld = (e_is == 0);
        hold_v = 0;
      end else if (e_mv) begin
        hold_v = 1; hold_s = e_is;
      end
      if (ld_acc) mlq.push_back(int'(ld_addr));
      if (st_acc) begin msq_a.push_back(int'(st_addr)); msq_d.push_back(int'(st_data)); end
    end
    @(negedge clk);
  endtask

  task automatic drive(bit lv, int la, bit sv, int sa, int sd, bit mr, bit fl);
    ld_valid = lv; ld_addr = AW'(la);
    st_valid = sv; st_addr = AW'(sa); st_data = DW'(sd);
    mem_ready = mr; flush = fl;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    drive(0, 0, 0, 0, 0, 0, 0); step("R1");
    // R3: one store; R4: load to its address held; R11: top bit differs, accepted
    drive(0, 0, 1, 5, 8'h11, 0, 0); step("R3");
    drive(1, 5, 0, 0, 0, 0, 0); step("R4");
    drive(1, 13, 0, 0, 0, 0, 0); step("R11");
    // R5: store to a queued load address held
    drive(0, 0, 1, 13, 8'h22, 0, 0); step("R5");
    drive(0, 0, 1, 13, 8'h22, 0, 0); step("R5");
    // R6: same cycle, same address
    drive(1, 7, 1, 7, 8'h33, 0, 0); step("R6");
    // R7: fill the load queue, then one more
    drive(1, 1, 0, 0, 0, 0, 0); step("R7");
    drive(1, 2, 0, 0, 0, 0, 0); step("R7");
    drive(1, 3, 0, 0, 0, 0, 0); step("R7");
    // R9: offer stalls
    drive(0, 0, 1, 9, 8'h44, 0, 0); step("R9");
    drive(0, 0, 0, 0, 0, 0, 0); step("R9");
    drive(0, 0, 0, 0, 0, 0, 0); step("R9");
    // R8, R2, R3: drain with alternation
    for (int k = 0; k < 10; k++) begin
      drive(0, 0, 0, 0, 0, 1, 0); step("R8 R2 R3");
    end
    // R10: flush with pending entries and same-cycle pushes
    drive(1, 4, 1, 6, 8'h55, 0, 0); step("R10");
    drive(1, 8, 1, 10, 8'h66, 0, 1); step("R10");
    drive(0, 0, 0, 0, 0, 0, 0); step("R10");
    drive(0, 0, 1, 11, 8'h77, 0, 0); step("R10");
    drive(1, 12, 0, 0, 0, 1, 0); step("R10 R8");
    drive(0, 0, 0, 0, 0, 1, 0); step("R10 R8");
    // Random traffic over a small address space
    for (int k = 0; k < 4000; k++) begin
      drive(($urandom % 3) != 0, $urandom % 16, ($urandom % 3) != 0, $urandom % 16,
            $urandom % 256, ($urandom % 4) != 0, ($urandom % 150) == 0);
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule